// File: doc/BRIEF.md
# Register File with Flag-Based Word Clearing

A small synchronous memory of six 8-bit words. It behaves as if every word were cleared by an asynchronous reset, yet the storage cells are never touched by reset. A one-bit "blank" marker per word records that the word still holds the reset value. A read of a blank word returns zero no matter what the cells contain, and the first write to a word removes its marker.

Writes come from a load strobe. The target word is picked by an internal write pointer that starts at word 0, steps by one on every load and wraps after the last word. Reads use a read enable and an address, and they pass through an output register. The value therefore appears one clock after the request, and the register keeps its value while no read is requested. A unit that fills a small table in sequence and reads it back at random can use this block as if the whole table were reset, while the storage itself stays a plain array with no reset.

Top module: `wreset_ram`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0 and every word is marked blank. After reset the write pointer points at word 0.
- R2: On a rising clock edge with `load` high, `wdata` is stored in the word at the write pointer, that word's blank marker is removed, and the pointer advances by one.
- R3: A load at the last word (5) wraps the write pointer back to word 0. Words 6 and 7 are never written.
- R4: With `ren` high, `rdata` shows the contents of word `raddr` after the next rising edge. Read latency is one clock.
- R5: After a reset, every word reads as 0 until it is written again, even if it held nonzero data before the reset. Writing one word leaves the other blank words reading 0.
- R6: With `ren` low, `rdata` keeps its previous value.
- R7: A read of address 6 or 7 returns 0 and changes no stored word.
- R8: If a read and a load hit the same word in the same cycle, the read returns the word's previous value. If that word was blank, the read returns 0.
- R9: While `rst_n` is low, loads are ignored. They neither store data nor move the write pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Write strobe for the word at the write pointer |
| wdata | input | 8 | Data to store |
| raddr | input | 3 | Read word address |
| ren | input | 1 | Read enable |
| rdata | output | 8 | Registered read data |

## Verification
On every cycle the embedded assertions check the pointer range and its wrap, that no blank marker is set again outside reset, that a read of a blank or out-of-range word yields zero, and that `rdata` holds while `ren` is low. Only the bench scenarios can show that the stored data is correct, that data written before a reset is hidden afterwards while the cells still hold it, and that loads applied during reset are dropped. They can also show the old-value result when a read and a write hit the same word.

// File: rtl/wreset_ram.sv
module wreset_ram #(
  parameter int WORDS = 6,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic          ren,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);
  localparam logic [AW-1:0] NW   = AW'(WORDS);

  logic [DW-1:0]    cells [WORDS];
  logic [WORDS-1:0] blank;
  logic [AW-1:0]    wptr;
  logic             hit;

  assign hit = (raddr < NW) && !blank[raddr];

  always_ff @(posedge clk)
    if (rst_n && load) cells[wptr] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blank <= '1;
      wptr  <= '0;
      rdata <= '0;
    end else begin
      if (load) begin
        blank[wptr] <= 1'b0;
        wptr        <= (wptr == LAST) ? '0 : wptr + 1'b1;
      end
      if (ren) rdata <= hit ? cells[raddr] : '0;
    end

  // R3
  p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wptr < NW);
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wptr == LAST) |=> wptr == '0);
  // R2
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wptr != LAST) |=> wptr == $past(wptr) + 1'b1);
  // R5
  p_blank_only_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (blank & ~$past(blank)) == '0);
  p_blank_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && raddr < NW && blank[raddr]) |=> rdata == '0);
  // R7
  p_oob_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && raddr >= NW) |=> rdata == '0);
  // R6
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> $stable(rdata));
endmodule

// File: tb/wreset_ram_bench.sv
module wreset_ram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] raddr = '0;
  logic       ren = 1'b0;
  logic [7:0] rdata;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wreset_ram u_wreset_ram (.clk, .rst_n, .load, .wdata, .raddr, .ren, .rdata);

  // {load, wdata, ren, raddr, expected rdata}
  localparam int N = 18;
  localparam logic [20:0] VEC [N] = '{
    {1'b1, 8'h11, 1'b0, 3'd0, 8'h00},  // R2
    {1'b1, 8'h22, 1'b0, 3'd0, 8'h00},
    {1'b1, 8'h33, 1'b0, 3'd0, 8'h00},
    {1'b1, 8'h44, 1'b0, 3'd0, 8'h00},
    {1'b1, 8'h55, 1'b0, 3'd0, 8'h00},
    {1'b1, 8'h66, 1'b0, 3'd0, 8'h00},
    {1'b0, 8'h00, 1'b1, 3'd0, 8'h11},  // R4
    {1'b0, 8'h00, 1'b1, 3'd1, 8'h22},
    {1'b0, 8'h00, 1'b1, 3'd2, 8'h33},
    {1'b0, 8'h00, 1'b1, 3'd3, 8'h44},
    {1'b0, 8'h00, 1'b1, 3'd4, 8'h55},
    {1'b0, 8'h00, 1'b1, 3'd5, 8'h66},
    {1'b0, 8'h00, 1'b1, 3'd6, 8'h00},  // R7
    {1'b0, 8'h00, 1'b1, 3'd7, 8'h00},
    {1'b0, 8'h00, 1'b1, 3'd2, 8'h33},
    {1'b0, 8'h00, 1'b0, 3'd5, 8'h33},  // R6
    {1'b1, 8'hA5, 1'b1, 3'd0, 8'h11},  // R8 old value, R3 wrap to 0
    {1'b0, 8'h00, 1'b1, 3'd0, 8'hA5}   // R3
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic l, input logic [7:0] d, input logic r, input logic [2:0] a);
    load = l; wdata = d; ren = r; raddr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      step(VEC[i][20], VEC[i][19:12], VEC[i][11], VEC[i][10:8]);
      check("R2/R3/R4/R6/R7/R8 table", rdata, VEC[i][7:0]);
    end
    rst_n = 1'b0;
    #1 check("R1", rdata, 8'h00);
    step(1'b1, 8'hEE, 1'b1, 3'd1);  // R9 load during reset
    check("R9", rdata, 8'h00);
    step(1'b1, 8'hEF, 1'b0, 3'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 6; a++) begin
      step(1'b0, 8'h00, 1'b1, 3'(a));
      check("R5", rdata, 8'h00);
    end
    step(1'b1, 8'h77, 1'b1, 3'd0);  // R8 blank word
    check("R8", rdata, 8'h00);
    step(1'b0, 8'h00, 1'b1, 3'd0);  // R1/R9 pointer at 0
    check("R9", rdata, 8'h77);
    for (int a = 1; a < 6; a++) begin
      step(1'b0, 8'h00, 1'b1, 3'(a));
      check("R5", rdata, 8'h00);
    end
    step(1'b1, 8'h88, 1'b0, 3'd0);
    step(1'b0, 8'h00, 1'b1, 3'd1);
    check("R2", rdata, 8'h88);
    step(1'b0, 8'h00, 1'b1, 3'd2);
    check("R5", rdata, 8'h00);
    step(1'b0, 8'h00, 1'b1, 3'd0);
    check("R5", rdata, 8'h77);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: rdata=%h expected=done", rdata);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule